// File: doc/BRIEF.md
# Local Interrupt Timer

A per-core countdown timer that raises an interrupt request carrying an 8-bit vector. Software programs a local vector word (vector, mask and mode), a divide selector and an initial count. Writing the initial count starts a fresh count. From that write, a prescaler produces one tick every 2^shift clock cycles. Each period lasts the initial count plus one ticks. In one-shot mode the timer fires once and then stops. In periodic mode it fires at every whole period measured from the load.

When an expiry happens, the request handshake latches the vector and holds `irq_valid` until the consumer accepts it with `irq_ready`. The handshake is valid/ready with these back-pressure rules:
- While `irq_valid` is high and `irq_ready` is low, the request stays pending.
- A further expiry during that wait is folded into the one pending request and refreshes the vector.
- An expiry in the same cycle as an acceptance leaves a new request pending.

The configuration port is a plain write strobe with a combinational read mux. `due_pending` reports whether an unmasked expiry is still scheduled.

Top module: `lt_timer`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), these hold:
  - The vector word reads 0x0001_0000 (mask set, one-shot mode, vector 0).
  - The initial count, divide selector and current count read 0.
  - `irq_valid` and `due_pending` are 0.
- R2: The register select is 0 = vector word, 1 = initial count, 2 = divide selector, 3 = current count.
  - The vector word holds the vector in bits 7:0, the mask in bit 16 and periodic mode (1) in bit 17. Its other bits read 0.
  - The divide selector uses bits 2:0 and its other bits read 0.
  - A write to select 3 has no effect.
- R3: Ticks occur every 2^shift clock cycles counted from the initial-count write, where shift is the divide selector value. The selector is captured at each initial-count write, so a divide write takes effect only at the next load.
- R4: In periodic mode with a nonzero count N, an expiry occurs at every tick whose number since the load is a multiple of N+1. The first expiry is visible one cycle after edge (N+1)*2^shift counted from the load edge.
- R5: In one-shot mode the first period boundary produces the only expiry. Afterwards the current count stays 0 and no further expiry occurs until the next load.
- R6: An initial count of zero never produces an expiry, in either mode, and leaves the current count at 0.
- R7: While the mask bit is set, no expiry raises a request, but counting continues. A one-shot boundary reached while masked still ends the count.
- R8: The current count reads N minus (ticks since load modulo N+1) while counting, and 0 when idle or after a one-shot expiry.
- R9: Requests follow the valid/ready handshake:
  - `irq_valid` rises on an expiry and stays high until a cycle with `irq_ready` high.
  - `irq_vector` is the vector word value at the expiry edge.
  - Expiries merge into a pending request, and an expiry wins over a same-cycle acceptance.
- R10: `due_pending` is 1 exactly when the count is armed (loaded nonzero and not finished) and the mask is clear. It is 0 otherwise.
- R11: An initial-count write in the middle of a count restarts the tick phase and the period from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_waddr | input | 2 | Register select for writes |
| cfg_wdata | input | 32 | Write data |
| cfg_raddr | input | 2 | Register select for reads |
| cfg_rdata | output | 32 | Read data (combinational) |
| irq_valid | output | 1 | Interrupt request pending |
| irq_ready | input | 1 | Consumer accepts the request |
| irq_vector | output | 8 | Vector of the pending request |
| due_pending | output | 1 | An unmasked expiry is scheduled |

## Verification
The hardest cases to reach from the ports are the ones where timing collides:
- an expiry arrives on the same edge as an acceptance, or while an earlier request is still unaccepted;
- the mode or divide selector changes partway through a count.

The stimulus draws irregular `irq_ready` patterns and interleaves random writes with short counts and small divides, so boundaries fall often. Directed phases hold `irq_ready` low across several periodic expiries. They also switch the divide selector and the mask partway through a count. Every cycle is compared against a bench model built from the tick and period arithmetic.

// File: rtl/lt_pkg.sv
package lt_pkg;
  localparam int VEC_W         = 8;
  localparam int LVT_MASK_BIT  = 16;
  localparam int LVT_MODE_BIT  = 17;

  typedef enum logic [1:0] {
    SEL_LVT  = 2'd0,
    SEL_INIT = 2'd1,
    SEL_DIV  = 2'd2,
    SEL_CUR  = 2'd3
  } sel_e;

  typedef struct packed {
    logic             periodic;
    logic             masked;
    logic [VEC_W-1:0] vector;
  } lvt_t;
endpackage

// File: rtl/lt_cfg_regs.sv
module lt_cfg_regs
  import lt_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int SHIFT_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [1:0]         waddr,
  input  logic [CNT_W-1:0]   wdata,
  input  logic [1:0]         raddr,
  input  logic [CNT_W-1:0]   cur_cnt,
  output lvt_t               lvt,
  output logic [CNT_W-1:0]   init_cnt,
  output logic [SHIFT_W-1:0] div_sel,
  output logic               load,
  output logic [CNT_W-1:0]   rdata
);
  logic unused_wbits;
  assign unused_wbits = ^{wdata[CNT_W-1:LVT_MODE_BIT+1], wdata[LVT_MASK_BIT-1:VEC_W]};

  assign load = we && (sel_e'(waddr) == SEL_INIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvt.periodic <= 1'b0;
      lvt.masked   <= 1'b1;
      lvt.vector   <= '0;
      init_cnt     <= '0;
      div_sel      <= '0;
    end else if (we) begin
      unique case (sel_e'(waddr))
        SEL_LVT: begin
          lvt.periodic <= wdata[LVT_MODE_BIT];
          lvt.masked   <= wdata[LVT_MASK_BIT];
          lvt.vector   <= wdata[VEC_W-1:0];
        end
        SEL_INIT: init_cnt <= wdata;
        SEL_DIV:  div_sel  <= wdata[SHIFT_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    unique case (sel_e'(raddr))
      SEL_LVT: begin
        rdata[VEC_W-1:0]    = lvt.vector;
        rdata[LVT_MASK_BIT] = lvt.masked;
        rdata[LVT_MODE_BIT] = lvt.periodic;
      end
      SEL_INIT: rdata = init_cnt;
      SEL_DIV:  rdata[SHIFT_W-1:0] = div_sel;
      default:  rdata = cur_cnt;
    endcase
  end
endmodule

// File: rtl/lt_prescaler.sv
module lt_prescaler #(
  parameter int SHIFT_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [SHIFT_W-1:0] div_sel,
  output logic               tick
);
  localparam int PRE_W = (1 << SHIFT_W) - 1;

  logic [SHIFT_W-1:0] shift_q;
  logic [PRE_W-1:0]   pre_q;
  logic [PRE_W-1:0]   lim;

  for (genvar i = 0; i < PRE_W; i++) begin : g_lim
    assign lim[i] = (32'(shift_q) > i);
  end

  assign tick = (pre_q == lim);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shift_q <= '0;
      pre_q   <= '0;
    end else if (load) begin
      shift_q <= div_sel;
      pre_q   <= '0;
    end else if (tick) begin
      pre_q   <= '0;
    end else begin
      pre_q   <= pre_q + PRE_W'(1);
    end
  end
endmodule

// File: rtl/lt_downcount.sv
module lt_downcount #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             periodic,
  input  logic             masked,
  input  logic             tick,
  output logic [CNT_W-1:0] cur,
  output logic             armed,
  output logic             expire
);
  logic boundary;
  assign boundary = armed && tick && (cur == '0);
  assign expire   = boundary && !masked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur   <= '0;
      armed <= 1'b0;
    end else if (load) begin
      cur   <= load_val;
      armed <= (load_val != '0);
    end else if (armed && tick) begin
      if (cur == '0) begin
        if (periodic) cur   <= reload_val;
        else          armed <= 1'b0;
      end else begin
        cur <= cur - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/lt_req.sv
module lt_req
  import lt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             expire,
  input  logic [VEC_W-1:0] vec_in,
  input  logic             ready,
  output logic             valid,
  output logic [VEC_W-1:0] vec_out
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid   <= 1'b0;
      vec_out <= '0;
    end else if (expire) begin
      valid   <= 1'b1;
      vec_out <= vec_in;
    end else if (ready) begin
      valid   <= 1'b0;
    end
  end
endmodule

// File: rtl/lt_timer.sv
module lt_timer
  import lt_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int SHIFT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_waddr,
  input  logic [CNT_W-1:0] cfg_wdata,
  input  logic [1:0]       cfg_raddr,
  output logic [CNT_W-1:0] cfg_rdata,
  output logic             irq_valid,
  input  logic             irq_ready,
  output logic [VEC_W-1:0] irq_vector,
  output logic             due_pending
);
  lvt_t               lvt;
  logic [CNT_W-1:0]   init_cnt;
  logic [CNT_W-1:0]   cur_cnt;
  logic [SHIFT_W-1:0] div_sel;
  logic               load;
  logic               tick;
  logic               armed;
  logic               expire;
  logic               lvt_mask;

  assign lvt_mask = lvt.masked;

  lt_cfg_regs #(.CNT_W(CNT_W), .SHIFT_W(SHIFT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .waddr(cfg_waddr), .wdata(cfg_wdata),
    .raddr(cfg_raddr), .cur_cnt(cur_cnt), .lvt(lvt), .init_cnt(init_cnt),
    .div_sel(div_sel), .load(load), .rdata(cfg_rdata)
  );

  lt_prescaler #(.SHIFT_W(SHIFT_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .load(load), .div_sel(div_sel), .tick(tick)
  );

  lt_downcount #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(cfg_wdata),
    .reload_val(init_cnt), .periodic(lvt.periodic), .masked(lvt.masked),
    .tick(tick), .cur(cur_cnt), .armed(armed), .expire(expire)
  );

  lt_req u_req (
    .clk(clk), .rst_n(rst_n), .expire(expire), .vec_in(lvt.vector),
    .ready(irq_ready), .valid(irq_valid), .vec_out(irq_vector)
  );

  assign due_pending = armed && !lvt.masked;
endmodule

// File: rtl/lt_timer_chk.sv
module lt_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lvt_mask,
  input logic             expire,
  input logic             irq_valid,
  input logic             irq_ready,
  input logic             due_pending,
  input logic [CNT_W-1:0] init_cnt,
  input logic [CNT_W-1:0] cur_cnt
);
  // R7
  mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvt_mask && !irq_valid) |=> !irq_valid);

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !irq_ready) |=> irq_valid);

  // R10
  due_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !due_pending |-> !expire);

  // R6
  zero_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (init_cnt == '0) |-> !expire);

  // R8
  cur_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_cnt <= init_cnt);
endmodule

bind lt_timer lt_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lvt_mask(lvt_mask), .expire(expire),
  .irq_valid(irq_valid), .irq_ready(irq_ready), .due_pending(due_pending),
  .init_cnt(init_cnt), .cur_cnt(cur_cnt)
);

// File: tb/sim_lt_timer.sv
`timescale 1ns/1ps
module sim_lt_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        d_we = 1'b0;
  logic [1:0]  d_waddr = '0;
  logic [31:0] d_wdata = '0;
  logic [1:0]  d_raddr = '0;
  logic        d_ready = 1'b1;
  logic [31:0] rdata;
  logic        irq_valid;
  logic [7:0]  irq_vector;
  logic        due_pending;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  lt_timer u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(d_we), .cfg_waddr(d_waddr),
    .cfg_wdata(d_wdata), .cfg_raddr(d_raddr), .cfg_rdata(rdata),
    .irq_valid(irq_valid), .irq_ready(d_ready), .irq_vector(irq_vector),
    .due_pending(due_pending)
  );

  // bench model
  longint m_init = 0, m_t = 0;
  bit       m_per = 0, m_mask = 1, m_loaded = 0, m_done = 0, m_pend = 0;
  bit [7:0] m_vec = 0, m_pvec = 0;
  bit [2:0] m_div = 0, m_shift = 0;

  function automatic longint exp_cur();
    longint e;
    if (!m_loaded || m_done || m_init == 0) return 0;
    e = m_t >> m_shift;
    return m_init - (e % (m_init + 1));
  endfunction

  function automatic longint exp_read(input logic [1:0] a);
    case (a)
      2'd0: return {46'd0, m_per, m_mask, 8'd0, m_vec};
      2'd1: return m_init;
      2'd2: return {61'd0, m_div};
      default: return exp_cur();
    endcase
  endfunction

  function automatic bit exp_due();
    return m_loaded && m_init != 0 && !m_done && !m_mask;
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    bit fire = 0;
    if (m_loaded) begin
      m_t++;
      if (m_init != 0 && !m_done && (m_t % (64'd1 << m_shift)) == 0 &&
          ((m_t >> m_shift) % (m_init + 1)) == 0) begin
        fire = !m_mask;
        if (!m_per) m_done = 1;
      end
    end
    if (fire) begin m_pend = 1; m_pvec = m_vec; end
    else if (d_ready) m_pend = 0;
    if (d_we) begin
      case (d_waddr)
        2'd0: begin m_vec = d_wdata[7:0]; m_mask = d_wdata[16]; m_per = d_wdata[17]; end
        2'd1: begin m_init = d_wdata; m_t = 0; m_loaded = 1; m_done = 0; m_shift = m_div; end
        2'd2: m_div = d_wdata[2:0];
        default: ;
      endcase
    end
  endtask

  task automatic check_outputs(input string tag);
    chk({tag, " irq_valid"}, irq_valid, m_pend);
    if (m_pend) chk({tag, " irq_vector"}, irq_vector, m_pvec);
    chk("R10 due_pending", due_pending, exp_due());
    chk(d_raddr == 2'd3 ? "R8 current count" : "R2 readback", rdata, exp_read(d_raddr));
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check_outputs(tag);
    d_we = 1'b0;
    d_raddr = d_raddr + 2'd1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] v, input string tag);
    d_we = 1'b1; d_waddr = a; d_wdata = v;
    step(tag);
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      d_raddr = a[1:0];
      #0.1;
      chk("R1 reset readback", rdata, a == 0 ? 32'h0001_0000 : 32'h0);
    end
    chk("R1 reset irq_valid", irq_valid, 0);
    chk("R1 reset due_pending", due_pending, 0);

    // R7 masked periodic, then unmask
    wr(2'd0, 32'h0003_0041, "R7");
    wr(2'd1, 32'd3, "R7");
    run(40, "R7");
    wr(2'd0, 32'h0002_0041, "R4");
    run(30, "R4");

    // R9 hold ready low across several expiries, vector change
    d_ready = 1'b0;
    wr(2'd0, 32'h0002_0077, "R9");
    run(25, "R9");
    d_ready = 1'b1;
    run(6, "R9");

    // R6 zero count in both modes
    wr(2'd1, 32'd0, "R6");
    run(20, "R6");
    wr(2'd0, 32'h0000_0012, "R6");
    wr(2'd1, 32'd0, "R6");
    run(20, "R6");

    // R3 divide latched at load; mid-count divide write ignored
    wr(2'd2, 32'd2, "R3");
    wr(2'd1, 32'd4, "R3");
    run(8, "R3");
    wr(2'd2, 32'd0, "R3");
    run(30, "R3");

    // R5 one-shot single expiry
    wr(2'd1, 32'd5, "R5");
    run(30, "R5");

    // R11 reload mid-count
    wr(2'd0, 32'h0002_0033, "R11");
    wr(2'd1, 32'd6, "R11");
    run(4, "R11");
    wr(2'd1, 32'd2, "R11");
    run(15, "R11");

    // R2 write to current count ignored
    d_raddr = 2'd2;
    wr(2'd3, 32'hFFFF_FFFF, "R2");
    run(3, "R2");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom % 48;
      d_ready = ($urandom % 3) != 0;
      d_raddr = $urandom % 4;
      if (r < 3) begin
        d_we = 1; d_waddr = 2'd1;
        d_wdata = ($urandom % 8 == 0) ? 32'd0 : ($urandom % 12);
      end else if (r < 5) begin
        d_we = 1; d_waddr = 2'd0;
        d_wdata = {14'd0, 1'($urandom), ($urandom % 4 == 0), 8'd0, 8'($urandom)};
      end else if (r < 7) begin
        d_we = 1; d_waddr = 2'd2; d_wdata = $urandom % 4;
      end else if (r < 8) begin
        d_we = 1; d_waddr = 2'd3; d_wdata = $urandom;
      end
      step(m_per ? "R4 random" : "R5 random");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(5ns * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule